// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block records which processors are present in a system as a 256-entry bitmap of one bit per processor. Software reads the bitmap one byte at a time through a 32-byte register window. Byte offset `k` holds processors `8k` to `8k+7`, and processor `8k+j` is bit `j` of that byte. Writes into the window are accepted and then ignored.

Hardware reports a processor arrival or departure with a one-cycle event carrying a 9-bit identifier and a direction flag. In the next cycle the event stage is in one of four states: `EV_IDLE`, `EV_PLUG`, `EV_UNPLUG` or `EV_BADID`. It leaves `EV_IDLE` for `EV_PLUG` or `EV_UNPLUG` when an event with an identifier below 256 arrives. It goes to `EV_BADID` when the identifier's top bit is set. With no event it returns to `EV_IDLE`. Any state can be followed directly by any other.

In `EV_PLUG` or `EV_UNPLUG`, the stage writes the addressed bit and drives a status mask of `0x04` towards the general-purpose event status register. It also pulses a request to re-evaluate the system control interrupt. In `EV_BADID` it only raises an error pulse. Reset loads the bits of the processors present at boot, numbered 0 to `BOOT_CPUS-1`, and raises no event.

Top module: `cpu_presence_map`

## Requirements
- R1: After reset, bits 0 to BOOT_CPUS-1 (default 4) read as 1 and all other bits read as 0. `gpe_mask`, `sci_eval` and `id_err` are all 0, so the initial population raises no event.
- R2: Identifier N maps to bit N mod 8 of the byte at window offset N div 8.
- R3: A plug event (`ev_plug`=1) sets the identified bit and leaves every other bit unchanged.
- R4: An unplug event (`ev_plug`=0) clears the identified bit and leaves every other bit unchanged.
- R5: In the cycle after an event with an identifier below 256 is sampled, `gpe_mask` equals 8'h04 (status bit 2) and `sci_eval` is 1. In all other cycles both are 0.
- R6: An identifier of 256 or above (bit 8 of `ev_id` set) leaves the bitmap unchanged and raises no `gpe_mask` or `sci_eval`. Instead, `id_err` is 1 for exactly the cycle after the event is sampled.
- R7: A read (`acc_en`=1, `acc_we`=0) sampled at a clock edge gives `rd_valid`=1 in the next cycle, with `rd_data` equal to the stored byte at `acc_addr`.
- R8: A read at an offset of 32 or above returns `rd_data`=0.
- R9: A write (`acc_en`=1, `acc_we`=1) changes no bit of the bitmap and gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the boot population |
| ev_valid | input | 1 | Processor event present this cycle |
| ev_plug | input | 1 | 1 = processor added, 0 = processor removed |
| ev_id | input | 9 | Processor identifier; values of 256 or above are invalid |
| acc_en | input | 1 | Window access strobe |
| acc_we | input | 1 | 1 = write (ignored), 0 = read |
| acc_addr | input | 6 | Byte offset within the window |
| acc_wdata | input | 8 | Write data (discarded) |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Bitmap byte returned by the read |
| gpe_mask | output | 8 | Status bits to OR into the event status register |
| sci_eval | output | 1 | Request to recompute the interrupt level |
| id_err | output | 1 | Pulse marking a rejected identifier |

## Verification
The assertions assume that events and accesses arrive as single-cycle strobes that are sampled only while reset is released. They also assume that `ev_id` and `ev_plug` are meaningful only when `ev_valid` is high. The bench drives every input at the falling clock edge and returns each strobe low after one cycle. It waits a full cycle after each event before reading, so every read sees the bitmap after the update has landed. Identifiers used for rejection have bit 8 set, and out-of-window offsets lie between 32 and 63.

// File: rtl/cpumap_pkg.sv
package cpumap_pkg;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_PLUG   = 2'd1,
        EV_UNPLUG = 2'd2,
        EV_BADID  = 2'd3
    } ev_state_e;

    // Reset value of one bitmap byte: bit j is set when processor
    // (byte_idx*8 + j) is among the first boot_cpus processors.
    function automatic logic [7:0] boot_byte(input int unsigned byte_idx,
                                             input int unsigned boot_cpus);
        logic [7:0] v;
        v = '0;
        for (int j = 0; j < 8; j++) begin
            if ((byte_idx * 8 + j) < boot_cpus) v[j] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/cpumap_evdec.sv
module cpumap_evdec
    import cpumap_pkg::*;
#(
    parameter int CPU_ID_W = 8,
    parameter int GPE_BIT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic                ev_plug,
    input  logic [CPU_ID_W:0]   ev_id,
    output logic                upd_valid,
    output logic                upd_set,
    output logic [CPU_ID_W-1:0] upd_id,
    output logic [7:0]          gpe_mask,
    output logic                sci_eval,
    output logic                id_err
);

    localparam logic [7:0] GPE_MASK = 8'(1 << GPE_BIT);

    ev_state_e             state_q, state_d;
    logic [CPU_ID_W-1:0]   id_q;

    // next-state selection
    always_comb begin
        if (!ev_valid) begin
            state_d = EV_IDLE;
        end else if (ev_id[CPU_ID_W]) begin
            state_d = EV_BADID;
        end else if (ev_plug) begin
            state_d = EV_PLUG;
        end else begin
            state_d = EV_UNPLUG;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= ev_id[CPU_ID_W-1:0];
        end
    end

    // outputs
    always_comb begin
        upd_valid = 1'b0;
        upd_set   = 1'b0;
        gpe_mask  = '0;
        sci_eval  = 1'b0;
        id_err    = 1'b0;
        unique case (state_q)
            EV_IDLE: begin
            end
            EV_PLUG: begin
                upd_valid = 1'b1;
                upd_set   = 1'b1;
                gpe_mask  = GPE_MASK;
                sci_eval  = 1'b1;
            end
            EV_UNPLUG: begin
                upd_valid = 1'b1;
                gpe_mask  = GPE_MASK;
                sci_eval  = 1'b1;
            end
            EV_BADID: begin
                id_err = 1'b1;
            end
        endcase
    end

    assign upd_id = id_q;

    p_event_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_id[CPU_ID_W]) |=> (sci_eval && gpe_mask == GPE_MASK && !id_err));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (!sci_eval && gpe_mask == '0 && !id_err));

    p_bad_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_id[CPU_ID_W]) |=> (id_err && !sci_eval && !upd_valid && gpe_mask == '0));

endmodule

// File: rtl/cpumap_store.sv
module cpumap_store
    import cpumap_pkg::*;
#(
    parameter int CPU_ID_W  = 8,
    parameter int BOOT_CPUS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_valid,
    input  logic                  upd_set,
    input  logic [CPU_ID_W-1:0]   upd_id,
    output logic [(1<<CPU_ID_W)-1:0] map
);

    localparam int NUM_CPUS = 1 << CPU_ID_W;
    localparam int BYTES    = NUM_CPUS / 8;
    localparam int BYTE_AW  = CPU_ID_W - 3;

    logic [7:0] bytes_q [BYTES];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam logic [BYTE_AW-1:0] B_IDX = BYTE_AW'(b);
        logic hit;
        assign hit = upd_valid && (upd_id[CPU_ID_W-1:3] == B_IDX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[b] <= boot_byte(b, BOOT_CPUS);
            end else if (hit) begin
                bytes_q[b][upd_id[2:0]] <= upd_set;
            end
        end

        assign map[b*8 +: 8] = bytes_q[b];
    end

    p_plug_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_set) |=> map[$past(upd_id)]);

    p_unplug_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_set) |=> !map[$past(upd_id)]);

    p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ($countones(map ^ $past(map)) <= 1));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(map));

endmodule

// File: rtl/cpumap_rdport.sv
module cpumap_rdport #(
    parameter int CPU_ID_W = 8,
    parameter int WIN_AW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic                     acc_we,
    input  logic [WIN_AW-1:0]        acc_addr,
    input  logic [(1<<CPU_ID_W)-1:0] map,
    output logic                     rd_valid,
    output logic [7:0]               rd_data
);

    localparam int BYTES   = (1 << CPU_ID_W) / 8;
    localparam int BYTE_AW = CPU_ID_W - 3;

    logic               is_read;
    logic               in_range;
    logic [BYTE_AW-1:0] byte_idx;

    assign is_read  = acc_en && !acc_we;
    assign in_range = (acc_addr < WIN_AW'(BYTES));
    assign byte_idx = acc_addr[BYTE_AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_read;
            if (is_read) begin
                rd_data <= in_range ? map[{byte_idx, 3'b000} +: 8] : 8'h00;
            end
        end
    end

    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);

    p_oor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_addr >= WIN_AW'(BYTES)) |=> (rd_data == 8'h00));

    p_wr_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we) |=> !rd_valid);

endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map #(
    parameter int CPU_ID_W  = 8,
    parameter int BOOT_CPUS = 4,
    parameter int GPE_BIT   = 2,
    parameter int WIN_AW    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic                ev_plug,
    input  logic [CPU_ID_W:0]   ev_id,
    input  logic                acc_en,
    input  logic                acc_we,
    input  logic [WIN_AW-1:0]   acc_addr,
    input  logic [7:0]          acc_wdata,
    output logic                rd_valid,
    output logic [7:0]          rd_data,
    output logic [7:0]          gpe_mask,
    output logic                sci_eval,
    output logic                id_err
);

    localparam int NUM_CPUS = 1 << CPU_ID_W;

    logic                upd_valid;
    logic                upd_set;
    logic [CPU_ID_W-1:0] upd_id;
    logic [NUM_CPUS-1:0] map;

    // write data has no destination
    logic unused_wdata;
    assign unused_wdata = ^acc_wdata;

    cpumap_evdec #(
        .CPU_ID_W (CPU_ID_W),
        .GPE_BIT  (GPE_BIT)
    ) u_evdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_plug   (ev_plug),
        .ev_id     (ev_id),
        .upd_valid (upd_valid),
        .upd_set   (upd_set),
        .upd_id    (upd_id),
        .gpe_mask  (gpe_mask),
        .sci_eval  (sci_eval),
        .id_err    (id_err)
    );

    cpumap_store #(
        .CPU_ID_W  (CPU_ID_W),
        .BOOT_CPUS (BOOT_CPUS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_set   (upd_set),
        .upd_id    (upd_id),
        .map       (map)
    );

    cpumap_rdport #(
        .CPU_ID_W (CPU_ID_W),
        .WIN_AW   (WIN_AW)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .map      (map),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/cpu_presence_map_tb.sv
`timescale 1ns/1ps
module cpu_presence_map_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_valid, ev_plug;
    logic [8:0] ev_id;
    logic       acc_en, acc_we;
    logic [5:0] acc_addr;
    logic [7:0] acc_wdata;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] gpe_mask;
    logic       sci_eval, id_err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [255:0] model;
    logic [7:0]   exp_q[$];
    string        req_q[$];

    always #4 clk = ~clk;

    cpu_presence_map u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_plug(ev_plug), .ev_id(ev_id),
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .gpe_mask(gpe_mask),
        .sci_eval(sci_eval), .id_err(id_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop expected read bytes as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected rd_valid", 1, 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(r, {24'h0, rd_data}, {24'h0, e});
            end
        end
    end

    task automatic do_read(input int addr, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = 6'(addr);
        exp_q.push_back(addr < 32 ? model[addr*8 +: 8] : 8'h00);
        req_q.push_back(req);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic do_write(input int addr, input logic [7:0] data);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 6'(addr); acc_wdata = data;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        chk("R9 write gives no rd_valid", {31'h0, rd_valid}, 0);
    endtask

    task automatic do_event(input logic plug, input int id);
        @(negedge clk);
        ev_valid = 1'b1; ev_plug = plug; ev_id = 9'(id);
        @(negedge clk);
        ev_valid = 1'b0;
        if (id < 256) begin
            chk("R5 gpe_mask", {24'h0, gpe_mask}, 32'h04);
            chk("R5 sci_eval", {31'h0, sci_eval}, 1);
            chk("R6 id_err on valid id", {31'h0, id_err}, 0);
            model[id] = plug;
        end else begin
            chk("R6 id_err", {31'h0, id_err}, 1);
            chk("R6 no gpe_mask", {24'h0, gpe_mask}, 0);
            chk("R6 no sci_eval", {31'h0, sci_eval}, 0);
        end
        @(negedge clk);
        chk("R5 pulse ends", {23'h0, gpe_mask, sci_eval, id_err}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ev_valid = 1'b0; ev_plug = 1'b0; ev_id = '0;
        acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
        model = '0;
        for (int i = 0; i < 4; i++) model[i] = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no event from boot population
        chk("R1 gpe_mask after reset", {24'h0, gpe_mask}, 0);
        chk("R1 sci_eval after reset", {31'h0, sci_eval}, 0);
        chk("R1 id_err after reset", {31'h0, id_err}, 0);
        chk("R1 rd_valid after reset", {31'h0, rd_valid}, 0);
        for (int a = 0; a < 32; a++) do_read(a, "R1 boot bitmap");

        // R2/R3: plug events
        do_event(1'b1, 9);
        do_read(1, "R2 id 9 -> byte 1 bit 1");
        do_event(1'b1, 255);
        do_read(31, "R2 id 255 -> byte 31 bit 7");
        do_event(1'b1, 200);
        do_read(25, "R3 plug id 200");
        do_event(1'b1, 0);
        do_read(0, "R3 plug already present");
        // R4: unplug events
        do_event(1'b0, 2);
        do_read(0, "R4 unplug id 2");
        do_event(1'b0, 100);
        do_read(12, "R4 unplug absent id 100");
        do_event(1'b0, 255);
        do_read(31, "R4 unplug id 255");
        do_event(1'b1, 40);
        do_event(1'b1, 47);
        do_read(5, "R3 two bits in byte 5");
        for (int a = 0; a < 32; a++) do_read(a, "R2 full map");

        // R6: rejected identifiers
        do_event(1'b1, 256);
        do_event(1'b0, 300);
        do_event(1'b1, 511);
        do_read(0, "R6 byte 0 unchanged");
        do_read(5, "R6 byte 5 unchanged");
        do_read(31, "R6 byte 31 unchanged");

        // R9: writes ignored
        do_write(1, 8'hFF);
        do_write(31, 8'hFF);
        do_write(0, 8'h00);
        do_read(1, "R9 byte 1 after write");
        do_read(31, "R9 byte 31 after write");
        do_read(0, "R9 byte 0 after write");

        // R8: out-of-window reads
        do_read(32, "R8 offset 32");
        do_read(45, "R8 offset 45");
        do_read(63, "R8 offset 63");

        // R7: last read byte in window
        do_read(25, "R7 read byte 25");

        repeat (3) @(negedge clk);
        chk("R7 all reads returned", exp_q.size(), 0);
        chk("R5 idle sci_eval", {31'h0, sci_eval}, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule